// File: doc/BRIEF.md
# Step Burst Generator

This block drives the step, direction and output-enable lines of one stepper motor channel. A strobe marks the start of each frame period. On that strobe the block takes in a control byte and two timing lengths. It then sends out a burst of step pulses inside the period. The upper two bits of the control byte set the direction level and the output-enable level. The output-enable level puts the bridge in conduction or in high impedance. The low bits give a pulse count, and the block sends twice that many pulses.

The programmed count is loaded into a wider remaining-count register with two zero bits appended. Each pulse subtracts two, so a 6-bit field yields 0 to 126 pulses in steps of 2. A pulse stays high for a set number of clocks, and a set number of low clocks separates one pulse from the next. All of these settings are captured at the strobe and held for the whole period. If the burst is still running when the next strobe arrives, the remaining pulses are dropped and an overrun flag is raised for the following period.

Top module: `step_burst_gen`

## Requirements
- R1: While reset is asserted and until the first strobe after it, step_o, dir_o, oe_o and overrun_o are all 0.
- R2: A strobe is sync_i high at a rising clock edge. At each strobe, ctl_i bit 7 (direction: 0 forward/clockwise, 1 reverse/counter-clockwise) is copied to dir_o and ctl_i bit 6 (1 conduct, 0 high impedance) is copied to oe_o. Both appear in the cycle after the strobe edge and hold until the next strobe.
- R3: With ctl_i bit 6 set, a period carries exactly 2*N step pulses, where N is ctl_i bits 5..0.
- R4: Each pulse is high for hi_len_i+1 clocks. Consecutive pulses are separated by gap_len_i+1 low clocks. The step line stays low after the last pulse.
- R5: When no pulse is in progress or pending at the strobe, the first pulse of a non-empty burst is high in the first cycle after the strobe edge.
- R6: A period with N = 0 or with ctl_i bit 6 clear produces no pulse.
- R7: Changes to ctl_i, hi_len_i or gap_len_i between strobes do not affect the running burst, dir_o or oe_o.
- R8: A strobe that arrives while a pulse is high or still pending drops the rest of the burst. It sets overrun_o from the next cycle until the next strobe. The new burst then begins with gap_len_i+1 low clocks before its first pulse.
- R9: A strobe that finds the burst complete clears overrun_o from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame period strobe |
| ctl_i | input | CNT_W+2 (8) | Control byte: direction, enable, pulse count |
| hi_len_i | input | TMR_W (4) | Pulse high time minus one, in clocks |
| gap_len_i | input | TMR_W (4) | Gap between pulses minus one, in clocks |
| step_o | output | 1 | Step pulse train |
| dir_o | output | 1 | Direction level |
| oe_o | output | 1 | Bridge output enable (1 conduct, 0 high impedance) |
| overrun_o | output | 1 | Previous burst was cut short by a strobe |

## Verification
All outputs come straight from registers. dir_o, oe_o and overrun_o change one cycle after the strobe edge. The first step pulse shows one cycle after the strobe edge, or gap_len_i+1 cycles later after an overrun. After that, pulse edges follow every hi_len_i+1 and gap_len_i+1 clocks. The bench drives inputs on falling edges and samples 1 ns after each rising edge. Sample zero of every period is therefore the first cycle after the strobe edge. Run lengths, pulse counts and levels are then compared against that cycle-exact schedule.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
    // Phase of the step sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_GAP  = 2'd2
    } phase_e;
endpackage

// File: rtl/sbg_timer.sv
// Down-counting phase timer: load a length, report when it reaches zero.
module sbg_timer #(
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] val_i,
    output logic             zero_o
);
    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = val_i;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign zero_o = (tmr_q.cnt == '0);
endmodule

// File: rtl/sbg_shadow.sv
// Per-period copy of direction, enable and timing lengths, refreshed at a strobe.
module sbg_shadow #(
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             dir_i,
    input  logic             en_i,
    input  logic [TMR_W-1:0] hi_i,
    input  logic [TMR_W-1:0] gap_i,
    output logic             dir_o,
    output logic             en_o,
    output logic [TMR_W-1:0] hi_o,
    output logic [TMR_W-1:0] gap_o
);
    typedef struct packed {
        logic             dir;
        logic             en;
        logic [TMR_W-1:0] hi;
        logic [TMR_W-1:0] gap;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.dir = dir_i;
            sh_d.en  = en_i;
            sh_d.hi  = hi_i;
            sh_d.gap = gap_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dir_o = sh_q.dir;
    assign en_o  = sh_q.en;
    assign hi_o  = sh_q.hi;
    assign gap_o = sh_q.gap;
endmodule

// File: rtl/sbg_seq.sv
// Burst sequencer: phase state, remaining pulse budget and overrun flag.
module sbg_seq
    import sbg_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [TMR_W-1:0] hi_i,
    input  logic [TMR_W-1:0] gap_i,
    input  logic [TMR_W-1:0] hi_sh_i,
    input  logic [TMR_W-1:0] gap_sh_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [TMR_W-1:0] tmr_val_o,
    output logic             step_o,
    output logic             overrun_o
);
    // Count register is two bits wider; its two low bits load as zero.
    localparam int CTR_W = CNT_W + 2;
    localparam logic [CTR_W-1:0] PER_PULSE = CTR_W'(2);

    typedef struct packed {
        phase_e           ph;
        logic [CTR_W-1:0] rem;
        logic             ovr;
    } seq_t;

    seq_t seq_d, seq_q;
    logic busy;
    logic start;

    assign busy  = (seq_q.ph != PH_IDLE);
    assign start = en_i && (cnt_i != '0);

    always_comb begin
        seq_d      = seq_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        if (sync_i) begin
            seq_d.ovr = busy;
            seq_d.rem = en_i ? {cnt_i, 2'b00} : '0;
            if (!start) begin
                seq_d.ph = PH_IDLE;
            end else if (busy) begin
                // Separate the cut-off pulse from the new burst.
                seq_d.ph   = PH_GAP;
                tmr_load_o = 1'b1;
                tmr_val_o  = gap_i;
            end else begin
                seq_d.ph   = PH_HIGH;
                tmr_load_o = 1'b1;
                tmr_val_o  = hi_i;
            end
        end else begin
            unique case (seq_q.ph)
                PH_HIGH: begin
                    if (tmr_zero_i) begin
                        seq_d.rem = seq_q.rem - PER_PULSE;
                        if (seq_q.rem == PER_PULSE) begin
                            seq_d.ph = PH_IDLE;
                        end else begin
                            seq_d.ph   = PH_GAP;
                            tmr_load_o = 1'b1;
                            tmr_val_o  = gap_sh_i;
                        end
                    end
                end
                PH_GAP: begin
                    if (tmr_zero_i) begin
                        seq_d.ph   = PH_HIGH;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = hi_sh_i;
                    end
                end
                default: seq_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, rem: '0, ovr: 1'b0};
        else        seq_q <= seq_d;
    end

    assign step_o    = (seq_q.ph == PH_HIGH);
    assign overrun_o = seq_q.ovr;
endmodule

// File: rtl/step_burst_gen.sv
module step_burst_gen #(
    parameter int CNT_W = 6,
    parameter int TMR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_i,
    input  logic [CNT_W+1:0]   ctl_i,
    input  logic [TMR_W-1:0]   hi_len_i,
    input  logic [TMR_W-1:0]   gap_len_i,
    output logic               step_o,
    output logic               dir_o,
    output logic               oe_o,
    output logic               overrun_o
);
    localparam int CTL_W   = CNT_W + 2;
    localparam int DIR_BIT = CTL_W - 1;
    localparam int EN_BIT  = CTL_W - 2;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic [TMR_W-1:0] hi_sh, gap_sh;

    sbg_shadow #(.TMR_W(TMR_W)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sync_i),
        .dir_i  (ctl_i[DIR_BIT]),
        .en_i   (ctl_i[EN_BIT]),
        .hi_i   (hi_len_i),
        .gap_i  (gap_len_i),
        .dir_o  (dir_o),
        .en_o   (oe_o),
        .hi_o   (hi_sh),
        .gap_o  (gap_sh)
    );

    sbg_seq #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_i),
        .en_i       (ctl_i[EN_BIT]),
        .cnt_i      (ctl_i[CNT_W-1:0]),
        .hi_i       (hi_len_i),
        .gap_i      (gap_len_i),
        .hi_sh_i    (hi_sh),
        .gap_sh_i   (gap_sh),
        .tmr_zero_i (tmr_zero),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .step_o     (step_o),
        .overrun_o  (overrun_o)
    );

    sbg_timer #(.TMR_W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );
endmodule

// File: rtl/sbg_chk.sv
module sbg_chk (
    input logic clk,
    input logic rst_n,
    input logic sync_i,
    input logic ctl_dir_i,
    input logic ctl_en_i,
    input logic step_o,
    input logic dir_o,
    input logic oe_o,
    input logic overrun_o
);
    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (dir_o == $past(ctl_dir_i)) && (oe_o == $past(ctl_en_i)));

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> $stable(dir_o) && $stable(oe_o));

    // R6
    no_step_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> !step_o);

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && step_o) |=> overrun_o && !step_o);

    // R9
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> $stable(overrun_o));
endmodule

bind step_burst_gen sbg_chk u_sbg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync_i),
    .ctl_dir_i (ctl_i[CNT_W+1]),
    .ctl_en_i  (ctl_i[CNT_W]),
    .step_o    (step_o),
    .dir_o     (dir_o),
    .oe_o      (oe_o),
    .overrun_o (overrun_o)
);

// File: tb/tb_step_burst_gen.sv
`timescale 1ns/1ps
module tb_step_burst_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_i = 1'b0;
    logic [7:0] ctl_i = 8'h00;
    logic [3:0] hi_len_i = 4'h0;
    logic [3:0] gap_len_i = 4'h0;
    logic       step_o, dir_o, oe_o, overrun_o;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;  // 250 MHz

    step_burst_gen dut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .ctl_i(ctl_i),
        .hi_len_i(hi_len_i), .gap_len_i(gap_len_i),
        .step_o(step_o), .dir_o(dir_o), .oe_o(oe_o), .overrun_o(overrun_o)
    );

    // Vector fields: {ctl[7:0], hi[3:0], gap[3:0], expected pulses[7:0]}
    localparam logic [23:0] VEC [6] = '{
        {8'h43, 4'd0, 4'd0, 8'd6},
        {8'hC5, 4'd2, 4'd1, 8'd10},
        {8'h87, 4'd1, 4'd1, 8'd0},
        {8'h40, 4'd0, 4'd0, 8'd0},
        {8'hFF, 4'd0, 4'd0, 8'd126},
        {8'h41, 4'd3, 4'd5, 8'd2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe one period, then watch step_o for 'window' samples.
    // Inputs are scrambled after the strobe (R7).
    task automatic run_period(input logic [7:0] ctl, input logic [3:0] hi,
                              input logic [3:0] gap, input int window,
                              output int pulses, output bit widths_ok,
                              output bit first_hi, output int lead_low);
        bit prev, cur, seen;
        int run;
        @(negedge clk);
        sync_i = 1'b1; ctl_i = ctl; hi_len_i = hi; gap_len_i = gap;
        @(posedge clk); #1;
        pulses = 0; widths_ok = 1'b1; prev = 1'b0; run = 0; seen = 1'b0;
        lead_low = 0; first_hi = 1'b0;
        for (int i = 0; i < window; i++) begin
            cur = step_o;
            if (i == 0) first_hi = cur;
            if (cur && !prev) begin
                pulses++;
                if (seen && run != int'(gap) + 1) widths_ok = 1'b0;
                run = 1;
            end else if (!cur && prev) begin
                if (run != int'(hi) + 1) widths_ok = 1'b0;
                seen = 1'b1;
                run = 1;
            end else begin
                run++;
            end
            if (!cur && pulses == 0) lead_low++;
            prev = cur;
            @(negedge clk);
            if (i == 0) begin
                sync_i = 1'b0; ctl_i = ~ctl; hi_len_i = ~hi; gap_len_i = ~gap;
            end
            @(posedge clk); #1;
        end
        if (prev) widths_ok = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog all requirements actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int pulses, lead, win, expn;
        bit wok, fhi;
        logic [7:0] c;
        logic [3:0] h, g;

        // R1: reset state, also just after release
        repeat (3) @(negedge clk);
        chk(step_o == 1'b0, "R1 step_o in reset", step_o, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(step_o == 1'b0, "R1 step_o", step_o, 0);
        chk(dir_o == 1'b0, "R1 dir_o", dir_o, 0);
        chk(oe_o == 1'b0, "R1 oe_o", oe_o, 0);
        chk(overrun_o == 1'b0, "R1 overrun_o", overrun_o, 0);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 6; v++) begin
            c = VEC[v][23:16]; h = VEC[v][15:12]; g = VEC[v][11:8];
            expn = int'(VEC[v][7:0]);
            win = ((expn > 0) ? expn : 2) * (int'(h) + int'(g) + 2) + 6;
            run_period(c, h, g, win, pulses, wok, fhi, lead);
            chk(pulses == expn, "R3/R6 pulse count", pulses, expn);
            chk(wok, "R4 pulse and gap widths", int'(wok), 1);
            chk(fhi == (expn > 0), "R5 first pulse right after strobe", int'(fhi), int'(expn > 0));
            chk(dir_o == c[7], "R2/R7 dir_o held", dir_o, c[7]);
            chk(oe_o == c[6], "R2/R7 oe_o held", oe_o, c[6]);
            chk(overrun_o == 1'b0, "R9 no overrun", overrun_o, 0);
        end

        // R8: strobe in the middle of a long burst
        run_period(8'h7F, 4'd1, 4'd1, 10, pulses, wok, fhi, lead);
        chk(pulses == 3, "R4 pulses before cut", pulses, 3);
        run_period(8'hC1, 4'd0, 4'd2, 20, pulses, wok, fhi, lead);
        chk(fhi == 1'b0, "R8 new burst starts low", int'(fhi), 0);
        chk(lead == 3, "R8 leading gap length", lead, 3);
        chk(pulses == 2, "R8 new burst count", pulses, 2);
        chk(wok, "R8 new burst widths", int'(wok), 1);
        chk(overrun_o == 1'b1, "R8 overrun_o held", overrun_o, 1);
        chk(dir_o == 1'b1, "R8 dir_o from new strobe", dir_o, 1);

        // R9 and R6: strobe after completion, zero count while enabled
        run_period(8'h40, 4'd0, 4'd0, 8, pulses, wok, fhi, lead);
        chk(overrun_o == 1'b0, "R9 overrun_o cleared", overrun_o, 0);
        chk(pulses == 0, "R6 zero count no pulse", pulses, 0);
        chk(oe_o == 1'b1, "R2 oe_o enabled", oe_o, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule